// File: doc/BRIEF.md
# Multi-Mode Slave Port Arbiter

This block decides which of several bus masters owns one slave port of a bus matrix. Each master raises a request line. The arbiter returns a registered one-hot grant, the index of the connected master and a flag that shows whether any master is connected at all. A transfer-done strobe marks the end of each beat. The arbiter changes its decision only on such a strobe, or while the slave is unconnected, so a grant never moves in the middle of a beat.

A two-bit mode input selects the policy. Three modes are round-robin and differ in what the slave does when it goes idle: it disconnects, it stays with the last owner, or it parks on a configured default master. These choices decide which masters get the slave with no wait and which ones wait one cycle. The fourth mode uses a fixed priority taken from per-master priority values. A slot counter caps how long one owner can hold the slave during a long burst.

The block has no data path, so it has no valid/ready interface. Every pin is a plain control or status signal. Configuration inputs (mode, priorities, default index, slot limit) are expected to change only while the slave is idle.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset the slave is unconnected, `grant` is all zero, and the round-robin search starts at master 0.
- R2: `grant` is zero when `connected` is low. Otherwise it has exactly one bit set, at position `grant_idx`.
- R3: State can change only at a clock edge where the slave is unconnected or `beat_done` is high. Otherwise grant, index and `connected` hold, even if the slot count has run out or the owner has dropped its request.
- R4: Each new grant loads `slot_limit` into a slot counter, which then counts down by one per clock and stops at zero. When `slot_limit` is non-zero and the counter is zero, the next `beat_done` re-arbitrates. With `beat_done` held high, an owner that keeps requesting therefore holds the slave for `slot_limit`+1 cycles.
- R5: When `slot_limit` is 0, an owner that keeps requesting keeps the slave for as long as it requests.
- R6: In modes 0, 1 and 2 the winner is the first requesting master found by searching upward from the master after the last one granted, wrapping modulo the master count. After reset the lowest-numbered requester therefore wins first. A new grant always goes to a master that was requesting.
- R7: In mode 0, a decision edge with no request pending disconnects the slave. A later request is granted at the first clock edge after it is raised.
- R8: In mode 1, a decision edge with no request pending leaves the slave connected to its last owner. That owner is served with no wait, and a different master is granted one edge after it requests.
- R9: In mode 2, a decision edge with no request pending connects the slave to `dflt_idx`. This includes the first edge after reset.
- R10: In mode 3, the requesting master with the largest priority value wins. The priority of master i is field i, `PRI_W` bits wide, of `prio`, with master 0 in the least significant bits. With no request pending, the slave disconnects.
- R11: In mode 3, among requesters that share the largest priority value, the highest-numbered master wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | Request line per master |
| prio | input | N_MST*PRI_W | Packed priority value per master (used in mode 3) |
| mode | input | 2 | 0 round-robin/disconnect, 1 round-robin/keep last, 2 round-robin/park default, 3 fixed priority |
| dflt_idx | input | $clog2(N_MST) | Park target in mode 2 |
| slot_limit | input | SLOT_W | Slot length in cycles; 0 disables the limit |
| beat_done | input | 1 | End of the current beat on the slave |
| grant | output | N_MST | One-hot grant |
| grant_idx | output | $clog2(N_MST) | Index of the connected master |
| connected | output | 1 | Slave is connected to a master |

## Verification
The properties assume that `mode`, `slot_limit` and `dflt_idx` are steady across the edge they describe, and that `dflt_idx` names an existing master. The bench changes these inputs only while reset is held, or at an idle point where no request is pending. It changes the request pattern and `beat_done` one time unit after an edge, so every decision sees inputs that were stable over the whole cycle. The bench sweeps every non-zero request pattern of a four-master setup under round-robin and priority arbitration, and walks each idle policy through its disconnect, hold and park cases.

// File: rtl/spa_pkg.sv
package spa_pkg;
  typedef enum logic [1:0] {
    ARB_RR_DROP = 2'd0,
    ARB_RR_HOLD = 2'd1,
    ARB_RR_PARK = 2'd2,
    ARB_PRIO    = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/spa_rr_picker.sv
// Rotating search: first requester at or after start, wrapping.
module spa_rr_picker #(
  parameter int N_MST = 8,
  localparam int IW = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req,
  input  logic [IW-1:0]    start,
  output logic             found,
  output logic [IW-1:0]    pick
);
  always_comb begin
    int c;
    logic [IW-1:0] ci;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N_MST; k++) begin
      c = int'(start) + k;
      if (c >= N_MST) c = c - N_MST;
      ci = IW'(c);
      if (!found && req[ci]) begin
        found = 1'b1;
        pick  = ci;
      end
    end
  end
endmodule

// File: rtl/spa_prio_picker.sv
// Largest priority wins; ">=" in an ascending scan favours high indices on ties.
module spa_prio_picker #(
  parameter int N_MST = 8,
  parameter int PRI_W = 3,
  localparam int IW = $clog2(N_MST)
) (
  input  logic [N_MST-1:0]       req,
  input  logic [N_MST*PRI_W-1:0] prio,
  output logic                   found,
  output logic [IW-1:0]          pick
);
  always_comb begin
    logic [PRI_W-1:0] best;
    logic [PRI_W-1:0] pv;
    found = 1'b0;
    pick  = '0;
    best  = '0;
    for (int i = 0; i < N_MST; i++) begin
      pv = prio[i*PRI_W +: PRI_W];
      if (req[i] && (!found || pv >= best)) begin
        found = 1'b1;
        best  = pv;
        pick  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spa_slot_timer.sv
module spa_slot_timer #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] limit,
  output logic              expired
);
  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= limit;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (limit != '0) && (cnt_q == '0);
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
  import spa_pkg::*;
#(
  parameter int N_MST  = 8,
  parameter int PRI_W  = 3,
  parameter int SLOT_W = 6,
  localparam int IW = $clog2(N_MST)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MST-1:0]       req,
  input  logic [N_MST*PRI_W-1:0] prio,
  input  logic [1:0]             mode,
  input  logic [IW-1:0]          dflt_idx,
  input  logic [SLOT_W-1:0]      slot_limit,
  input  logic                   beat_done,
  output logic [N_MST-1:0]       grant,
  output logic [IW-1:0]          grant_idx,
  output logic                   connected
);
  arb_mode_e     mode_e;
  logic          conn_q, conn_d;
  logic [IW-1:0] own_q, own_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          rr_found, pr_found, win_found;
  logic [IW-1:0] rr_pick, pr_pick, win;
  logic          expired, load, decide, keep;

  assign mode_e = arb_mode_e'(mode);

  spa_rr_picker #(.N_MST(N_MST)) u_rr (
    .req(req), .start(ptr_q), .found(rr_found), .pick(rr_pick)
  );

  spa_prio_picker #(.N_MST(N_MST), .PRI_W(PRI_W)) u_pri (
    .req(req), .prio(prio), .found(pr_found), .pick(pr_pick)
  );

  spa_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(load), .limit(slot_limit), .expired(expired)
  );

  assign win       = (mode_e == ARB_PRIO) ? pr_pick  : rr_pick;
  assign win_found = (mode_e == ARB_PRIO) ? pr_found : rr_found;
  assign decide    = !conn_q || beat_done;
  assign keep      = conn_q && req[own_q] && !expired;

  always_comb begin
    conn_d = conn_q;
    own_d  = own_q;
    ptr_d  = ptr_q;
    load   = 1'b0;
    if (decide && !keep) begin
      load = 1'b1;
      if (win_found) begin
        conn_d = 1'b1;
        own_d  = win;
        ptr_d  = (win == IW'(N_MST - 1)) ? '0 : win + 1'b1;
      end else begin
        case (mode_e)
          ARB_RR_HOLD: conn_d = conn_q;
          ARB_RR_PARK: begin
            conn_d = 1'b1;
            own_d  = dflt_idx;
          end
          default:     conn_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      own_q  <= '0;
      ptr_q  <= '0;
    end else begin
      conn_q <= conn_d;
      own_q  <= own_d;
      ptr_q  <= ptr_d;
    end
  end

  always_comb begin
    grant = '0;
    if (conn_q) grant[own_q] = 1'b1;
  end

  assign grant_idx = own_q;
  assign connected = conn_q;
endmodule

// File: rtl/spa_chk.sv
module spa_chk
  import spa_pkg::*;
#(
  parameter int N_MST  = 8,
  parameter int SLOT_W = 6,
  localparam int IW = $clog2(N_MST)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MST-1:0]  req,
  input logic [1:0]        mode,
  input logic [IW-1:0]     dflt_idx,
  input logic [SLOT_W-1:0] slot_limit,
  input logic              beat_done,
  input logic [N_MST-1:0]  grant,
  input logic [IW-1:0]     grant_idx,
  input logic              connected
);
  // R2
  grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (connected == (grant != '0)));

  // R2
  grant_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    connected |-> grant[grant_idx]);

  // R3
  mid_beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (connected && !beat_done) |=> (connected && $stable(grant_idx)));

  // R5
  no_slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (connected && slot_limit == '0 && req[grant_idx]) |=> (connected && $stable(grant_idx)));

  // R6
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!connected && req != '0) |=> (connected && (($past(req) & grant) != '0)));

  // R7
  drop_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ARB_RR_DROP && beat_done && req == '0) |=> !connected);

  // R8
  hold_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ARB_RR_HOLD && connected && beat_done && req == '0) |=> (connected && $stable(grant_idx)));

  // R9
  park_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ARB_RR_PARK && beat_done && req == '0) |=> (connected && grant_idx == $past(dflt_idx)));
endmodule

bind slave_port_arbiter spa_chk #(.N_MST(N_MST), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .dflt_idx(dflt_idx),
  .slot_limit(slot_limit), .beat_done(beat_done), .grant(grant),
  .grant_idx(grant_idx), .connected(connected)
);

// File: tb/slave_port_arbiter_bench.sv
module slave_port_arbiter_bench;
  localparam int N = 4, PW = 2, SW = 4, IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*PW-1:0] prio = '0;
  logic [1:0]    mode = 2'd0;
  logic [IW-1:0] dflt = '0;
  logic [SW-1:0] slot = '0;
  logic          beat = 1'b0;
  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;
  logic          connected;
  int checks = 0, errors = 0;

  slave_port_arbiter #(.N_MST(N), .PRI_W(PW), .SLOT_W(SW)) u_slave_port_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .mode(mode),
    .dflt_idx(dflt), .slot_limit(slot), .beat_done(beat),
    .grant(grant), .grant_idx(grant_idx), .connected(connected)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_owner(input string tag, input int exp);
    chk(connected && int'(grant_idx) == exp && grant == N'(1 << exp),
        {tag, " R2 owner"}, connected ? int'(grant_idx) : -1, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    step(2);
    rst_n = 1'b1;
  endtask

  function automatic int next_after(input int p, input int cur);
    for (int k = 1; k <= N; k++) begin
      if (p[(cur + k) % N]) return (cur + k) % N;
    end
    return cur;
  endfunction

  function automatic int prio_of(input int s, input int i);
    case (s)
      0: return 0;
      1: return i % 4;
      2: return 3 - i;
      3: return (i * 3 + 1) % 4;
      default: return 2;
    endcase
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(!connected && grant == '0, "R1 reset", int'(connected), 0);

    // R4 R6: rotating order and slot length over every request pattern
    mode = 2'd0;
    beat = 1'b1;
    for (int p = 1; p < 16; p++) begin
      int cur, held, lim;
      lim = p % 3 + 1;
      slot = SW'(lim);
      do_reset();
      req = N'(p);
      cur = 0;
      while (!p[cur]) cur++;
      held = 0;
      for (int c = 0; c < 12; c++) begin
        step(1);
        chk_owner("R4 R6 rotation", cur);
        held++;
        if (held == lim + 1) begin
          held = 0;
          cur = next_after(p, cur);
        end
      end
    end

    // R10 R11: fixed priority sweep
    mode = 2'd3;
    slot = '0;
    for (int s = 0; s < 5; s++) begin
      for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(prio_of(s, i));
      for (int p = 1; p < 16; p++) begin
        int exp, best;
        req = '0;
        step(1);
        chk(!connected, "R10 idle disconnect", int'(connected), 0);
        exp = -1;
        best = -1;
        for (int i = 0; i < N; i++)
          if (p[i] && prio_of(s, i) >= best) begin best = prio_of(s, i); exp = i; end
        req = N'(p);
        step(1);
        chk_owner((s == 0 || s == 4) ? "R11 tie" : "R10 priority", exp);
      end
    end

    // R7: disconnect policy
    mode = 2'd0;
    req = '0;
    do_reset();
    req = 4'b0100;
    step(1);
    chk_owner("R7 first grant", 2);
    req = '0;
    step(1);
    chk(!connected, "R7 disconnect", int'(connected), 0);
    req = 4'b0100;
    chk(!connected, "R7 latency before edge", int'(connected), 0);
    step(1);
    chk_owner("R7 regrant", 2);

    // R8: keep last owner
    mode = 2'd1;
    do_reset();
    req = 4'b0100;
    step(1);
    chk_owner("R8 first grant", 2);
    req = '0;
    step(4);
    chk_owner("R8 stays", 2);
    req = 4'b0100;
    chk_owner("R8 no wait", 2);
    req = 4'b0001;
    chk_owner("R8 other waits", 2);
    step(1);
    chk_owner("R8 other granted", 0);

    // R9: park on default
    mode = 2'd2;
    for (int d = 0; d < N; d++) begin
      dflt = IW'(d);
      do_reset();
      step(1);
      chk_owner("R9 park after reset", d);
      req = N'(1 << ((d + 1) % N));
      step(1);
      chk_owner("R9 other", (d + 1) % N);
      req = '0;
      step(1);
      chk_owner("R9 return", d);
      req = N'(1 << d);
      chk_owner("R9 default no wait", d);
      step(1);
      chk_owner("R9 default keeps", d);
    end

    // R3: no change without beat_done
    mode = 2'd0;
    slot = 4'd1;
    do_reset();
    beat = 1'b0;
    req = 4'b0011;
    step(1);
    chk_owner("R3 grant from idle", 0);
    step(5);
    chk_owner("R3 expired slot waits for beat", 0);
    req = 4'b0010;
    step(2);
    chk_owner("R3 dropped owner waits for beat", 0);
    beat = 1'b1;
    step(1);
    chk_owner("R3 switch on beat", 1);

    // R5: zero slot limit
    slot = '0;
    do_reset();
    req = 4'b1111;
    step(1);
    chk_owner("R5 first", 0);
    for (int c = 0; c < 20; c++) begin
      step(1);
      chk_owner("R5 unlimited hold", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule